// File: doc/BRIEF.md
# UART Receive Holding Buffer

This block sits between a UART receiver front end and the host side of a serial channel. It holds up to four received bytes in arrival order. The front end offers bytes on a valid/ready stream, and the host drains them through a second valid/ready stream. A separate strobe reports a line break. Each break inserts a zero byte and raises a sticky break-change flag.

The block drives two status flags, receive-ready and full. Its `in_ready` output doubles as the flow-control signal back to the receiver. A receiver-enable input gates the acceptance of normal bytes, and a flush strobe discards everything held.

On the input stream, a beat transfers only when `in_valid` and `in_ready` are both high at a clock edge. A beat presented while `in_ready` is low is lost, and `ovr_o` reports it. On the output stream, a byte leaves when `out_valid` and `out_ready` are both high. `out_ready` may be held high with no penalty, because a pop request against an empty buffer is ignored.

Top module: `rx_hold_buffer`

## Requirements
- R1: Up to DEPTH (default 4) bytes are held and delivered on `out_data` in the order they were stored.
- R2: `out_valid` (receive ready) is high whenever at least one byte is held. It falls only after a pop that leaves the buffer empty, or after a flush.
- R3: `full_o` is high exactly when DEPTH bytes are held. Any pop that is not refilled by a break in the same cycle clears it.
- R4: `in_ready` is high only when `rx_en` is high, the buffer is not full and `brk_evt` is low.
- R5: A `brk_evt` strobe sets `brk_flag` on the next edge and stores a 0x00 byte, whether or not `rx_en` is high. A `brk_clr` strobe clears the flag. A set in the same cycle as a clear wins.
- R6: A break that arrives while the buffer is full, with no pop in the same cycle, replaces the most recently stored byte with 0x00 and leaves the count at DEPTH.
- R7: While the buffer is empty, `out_data` is 0x00, and asserting `out_ready` changes no state.
- R8: A `flush` strobe empties the buffer and clears receive ready and full. It takes priority over any push or break in the same cycle.
- R9: A beat with `in_valid` high and `in_ready` low is dropped. `ovr_o` is high during the following cycle, and low after a cycle with no dropped beat.
- R10: A push and a pop in the same cycle are served pop first, so the count is unchanged and the pushed byte goes to the tail.
- R11: After reset the buffer is empty and `out_valid`, `full_o`, `brk_flag` and `ovr_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; gates acceptance of normal bytes |
| flush | input | 1 | Receiver-reset strobe; empties the buffer |
| in_valid | input | 1 | Front end offers a byte |
| in_ready | output | 1 | Buffer can accept a normal byte (flow control) |
| in_data | input | DW | Offered byte |
| brk_evt | input | 1 | Break detected strobe; inserts a zero byte |
| brk_clr | input | 1 | Clears the break-change flag |
| out_valid | output | 1 | Receive ready: a byte is available |
| out_ready | input | 1 | Host pops the head byte |
| out_data | output | DW | Head byte, or zero when empty |
| full_o | output | 1 | Buffer holds DEPTH bytes |
| brk_flag | output | 1 | Sticky break-change flag |
| ovr_o | output | 1 | One-cycle report of a dropped beat |

## Verification
The bench goes after a break that arrives while the buffer is full. A design that advanced the tail pointer there would wrap onto the oldest byte and corrupt the head, instead of replacing the newest entry. The bench also pops an empty buffer with `out_ready` held high. A design that let that request through would underflow its count and report a phantom full or valid. A simultaneous push and pop checks that the count stays put and that order is kept; a design that served the push first would lose the byte or reorder the stream. Flush and disabled-receiver cases check that dropped beats raise the overrun pulse and that flags return to their idle values.

// File: rtl/rxhb_pkg.sv
package rxhb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_FLUSH  = 3'd1,
    OP_BRK    = 3'd2,
    OP_BRK_OW = 3'd3,
    OP_PUSH   = 3'd4
  } store_op_e;
endpackage

// File: rtl/rxhb_arb.sv
module rxhb_arb #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  rx_en,
  input  logic                  flush,
  input  logic                  in_valid,
  input  logic                  brk_evt,
  input  logic                  out_ready,
  input  logic [CW-1:0]         count,
  output logic                  in_ready,
  output logic                  do_pop,
  output logic                  drop,
  output rxhb_pkg::store_op_e   op
);
  import rxhb_pkg::*;

  logic not_full;
  logic not_empty;
  logic full_after_pop;

  assign not_full  = (count != CW'(DEPTH));
  assign not_empty = (count != '0);
  assign in_ready  = rx_en && not_full && !brk_evt;
  assign do_pop    = out_ready && not_empty && !flush;
  assign drop      = in_valid && !in_ready;
  assign full_after_pop = !not_full && !do_pop;

  always_comb begin
    if (flush) begin
      op = OP_FLUSH;
    end else if (brk_evt) begin
      op = full_after_pop ? OP_BRK_OW : OP_BRK;
    end else if (in_valid && in_ready) begin
      op = OP_PUSH;
    end else begin
      op = OP_IDLE;
    end
  end
endmodule

// File: rtl/rxhb_mem.sv
module rxhb_mem #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (we && (waddr == PW'(g))) begin
        slot[g] <= wdata;
      end
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/rxhb_ctrl.sv
module rxhb_ctrl #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rxhb_pkg::store_op_e op,
  input  logic                do_pop,
  input  logic                drop,
  input  logic                brk_evt,
  input  logic                brk_clr,
  input  logic [DW-1:0]       in_data,
  output logic [CW-1:0]       count,
  output logic [PW-1:0]       head,
  output logic                we,
  output logic [PW-1:0]       waddr,
  output logic [DW-1:0]       wdata,
  output logic                brk_flag,
  output logic                ovr_o
);
  import rxhb_pkg::*;

  logic [PW-1:0] tail;
  logic [PW-1:0] tail_inc;
  logic [PW-1:0] tail_dec;
  logic [PW-1:0] head_inc;
  logic [CW-1:0] cnt_popped;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] wrap_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
  endfunction

  assign tail_inc   = wrap_inc(tail);
  assign tail_dec   = wrap_dec(tail);
  assign head_inc   = wrap_inc(head);
  assign cnt_popped = count - CW'(do_pop);

  always_comb begin
    we    = 1'b0;
    waddr = tail;
    wdata = in_data;
    unique case (op)
      OP_BRK:    begin we = 1'b1; wdata = '0; end
      OP_BRK_OW: begin we = 1'b1; wdata = '0; waddr = tail_dec; end
      OP_PUSH:   begin we = 1'b1; end
      default:   begin we = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      head  <= '0;
      tail  <= '0;
    end else begin
      unique case (op)
        OP_FLUSH: begin
          count <= '0;
          head  <= '0;
          tail  <= '0;
        end
        OP_BRK, OP_PUSH: begin
          count <= cnt_popped + CW'(1);
          tail  <= tail_inc;
          if (do_pop) head <= head_inc;
        end
        OP_BRK_OW: begin
          count <= count;
        end
        default: begin
          count <= cnt_popped;
          if (do_pop) head <= head_inc;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_flag <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      ovr_o <= drop;
      if (brk_evt) begin
        brk_flag <= 1'b1;
      end else if (brk_clr) begin
        brk_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_hold_buffer.sv
module rx_hold_buffer #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          brk_evt,
  input  logic          brk_clr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          full_o,
  output logic          brk_flag,
  output logic          ovr_o
);
  import rxhb_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] count;
  logic [PW-1:0] head;
  logic [PW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          we;
  logic          do_pop;
  logic          drop;
  store_op_e     op;

  rxhb_arb #(.DEPTH(DEPTH)) arb_i (
    .rx_en(rx_en), .flush(flush), .in_valid(in_valid), .brk_evt(brk_evt),
    .out_ready(out_ready), .count(count), .in_ready(in_ready),
    .do_pop(do_pop), .drop(drop), .op(op)
  );

  rxhb_ctrl #(.DEPTH(DEPTH), .DW(DW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .op(op), .do_pop(do_pop), .drop(drop),
    .brk_evt(brk_evt), .brk_clr(brk_clr), .in_data(in_data),
    .count(count), .head(head), .we(we), .waddr(waddr), .wdata(wdata),
    .brk_flag(brk_flag), .ovr_o(ovr_o)
  );

  rxhb_mem #(.DEPTH(DEPTH), .DW(DW)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(head), .rdata(rdata)
  );

  assign out_valid = (count != '0);
  assign full_o    = (count == CW'(DEPTH));
  assign out_data  = out_valid ? rdata : '0;
endmodule

// File: rtl/rx_hold_buffer_chk.sv
module rx_hold_buffer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          flush,
  input logic          in_valid,
  input logic          in_ready,
  input logic          brk_evt,
  input logic          brk_clr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          full_o,
  input logic          brk_flag,
  input logic          ovr_o
);
  a_r3_full_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !in_ready);
  a_r4_disabled_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || brk_evt) |-> !in_ready);
  a_r7_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));
  a_r7_empty_pop_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !brk_evt && !(in_valid && in_ready)) |=> !out_valid);
  a_r9_drop_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ovr_o);
  a_r9_no_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !in_ready) |=> !ovr_o);
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !full_o));
  a_r5_break_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag);
  a_r5_break_gives_data: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && !flush) |=> out_valid);
  a_r6_full_break_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && brk_evt && !flush) |=> full_o);
  a_r10_pushpop_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_valid && in_ready && !flush) |=> out_valid);
  a_r2_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> out_valid);
endmodule

bind rx_hold_buffer rx_hold_buffer_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush),
  .in_valid(in_valid), .in_ready(in_ready), .brk_evt(brk_evt),
  .brk_clr(brk_clr), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .full_o(full_o), .brk_flag(brk_flag), .ovr_o(ovr_o)
);

// File: tb/rx_hold_buffer_tb_top.sv
module rx_hold_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, flush = 1'b0, in_valid = 1'b0, brk_evt = 1'b0;
  logic brk_clr = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, full_o, brk_flag, ovr_o;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_hold_buffer #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .brk_evt(brk_evt), .brk_clr(brk_clr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .full_o(full_o),
    .brk_flag(brk_flag), .ovr_o(ovr_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk({req, " valid"}, int'(out_valid), int'(exp_q.size() != 0));
    chk({req, " full"}, int'(full_o), int'(exp_q.size() == DEPTH));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver: offers one beat, records it in the scoreboard if accepted
  task automatic drive_byte(input logic [DW-1:0] d, input string req);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    #1;
    acc = rx_en && (exp_q.size() < DEPTH);
    chk({req, " in_ready"}, int'(in_ready), int'(acc));
    @(negedge clk);
    in_valid = 1'b0;
    if (acc) exp_q.push_back(d);
    chk({req, " R9 ovr"}, int'(ovr_o), int'(!acc));
    chk_flags(req);
  endtask

  // monitor: pops one byte and compares it with the scoreboard head
  task automatic take_byte(input string req);
    @(negedge clk);
    #1;
    chk({req, " data"}, int'(out_data), (exp_q.size() != 0) ? int'(exp_q[0]) : 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    if (exp_q.size() != 0) void'(exp_q.pop_front());
    chk_flags(req);
  endtask

  task automatic push_and_pop(input logic [DW-1:0] d);
    @(negedge clk);
    #1;
    chk("R10 head", int'(out_data), int'(exp_q[0]));
    in_valid = 1'b1; in_data = d; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    void'(exp_q.pop_front());
    exp_q.push_back(d);
    chk_flags("R10");
  endtask

  task automatic send_break(input string req);
    @(negedge clk);
    brk_evt = 1'b1;
    @(negedge clk);
    brk_evt = 1'b0;
    if (exp_q.size() == DEPTH) exp_q[DEPTH-1] = '0;
    else exp_q.push_back('0);
    chk({req, " R5 flag"}, int'(brk_flag), 1);
    chk_flags(req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", int'(out_valid), 0);
    chk("R11 full", int'(full_o), 0);
    chk("R11 brk", int'(brk_flag), 0);
    chk("R11 ovr", int'(ovr_o), 0);
    chk("R11 data", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 disabled receiver refuses, R9 overrun raised
    drive_byte(8'h11, "R4 disabled");
    @(negedge clk);
    chk("R9 pulse ends", int'(ovr_o), 0);
    rx_en = 1'b1;
    // R1 order, R2 valid
    drive_byte(8'hA1, "R1"); drive_byte(8'hB2, "R1"); drive_byte(8'hC3, "R1");
    take_byte("R1"); take_byte("R2"); take_byte("R2 last");
    // R3 fill, refuse, clear on read
    for (int i = 0; i < DEPTH; i++) drive_byte(8'h40 + 8'(i), "R3 fill");
    drive_byte(8'hEE, "R3 full refuse");
    take_byte("R3 read clears");
    drive_byte(8'h55, "R3 refill");
    // R6 break on full overwrites newest
    send_break("R6");
    @(negedge clk);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    chk("R5 clear", int'(brk_flag), 0);
    // R5 break with set and clear together, receiver disabled
    take_byte("R6 drain"); take_byte("R6 drain");
    rx_en = 1'b0;
    @(negedge clk);
    brk_clr = 1'b1;
    send_break("R5 disabled");
    brk_clr = 1'b0;
    rx_en = 1'b1;
    while (exp_q.size() != 0) take_byte("R6 drain");
    // R7 empty read returns zero and changes nothing
    take_byte("R7 empty");
    take_byte("R7 empty");
    drive_byte(8'h77, "R7 after");
    take_byte("R7 after");
    // R10 simultaneous push and pop
    drive_byte(8'h01, "R10"); drive_byte(8'h02, "R10");
    push_and_pop(8'h03);
    push_and_pop(8'h04);
    take_byte("R10 drain"); take_byte("R10 drain");
    // R8 flush, with a push offered in the same cycle
    for (int i = 0; i < DEPTH; i++) drive_byte(8'h90 + 8'(i), "R8 fill");
    take_byte("R8 pre");
    @(negedge clk);
    flush = 1'b1; in_valid = 1'b1; in_data = 8'hDD;
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    exp_q.delete();
    chk_flags("R8 flush");
    chk("R8 data", int'(out_data), 0);
    drive_byte(8'h5A, "R8 after");
    take_byte("R8 after");
    finish_run();
  end
endmodule